// File: doc/BRIEF.md
# Parallel SAR Converter Sequencer

This block runs a 16-bit successive-approximation converter with a parallel result bus from the host side of a synchronous design. A sample-rate timer fires conversions at a programmed interval. For each conversion the block lowers the active-low chip select, pulses the read/convert line low, and waits for the converter's busy flag to fall and rise again. It then reads the two's-complement result and emits it on a one-cycle valid/data stream. The data is sign-extended to a wider output word.

The converter also reports a latchup-protection condition on a status line. While that status is raised, the sequencer pulls both control lines low and drops any conversion in flight. Once the status clears, it waits a settle interval, resumes sampling and marks the first new sample as suspect. If busy never returns high, a watchdog sets a sticky error and the sequencer goes back to waiting for the next tick.

The state machine has seven states:
- `ST_IDLE`: both control lines high. A timer tick moves it to `ST_SETUP`.
- `ST_SETUP`: chip select low for one cycle, then on to `ST_PULSE`.
- `ST_PULSE`: read/convert low for `PULSE_MIN` cycles, then on to `ST_WAIT`.
- `ST_WAIT`: a synchronised busy rising edge moves it to `ST_CAPTURE`. Expiry of the timeout moves it back to `ST_IDLE`.
- `ST_CAPTURE`: takes the result, then returns to `ST_IDLE`.
- `ST_PROTECT`: entered from any state when the synchronised status is high. It leaves for `ST_SETTLE` when the status drops.
- `ST_SETTLE`: lasts `SETTLE_CYC` cycles, then returns to `ST_IDLE`.

Top module: `sar_host_ctrl`

## Requirements
- R1: After reset, `adc_cs_n` and `adc_rc` are 1, and `smp_valid`, `smp_suspect` and `timeout_err` are 0.
- R2: Each conversion drives `adc_cs_n` low for one cycle before `adc_rc` falls. `adc_rc` then stays low for exactly `PULSE_MIN` cycles, and `adc_rc` is never low while `adc_cs_n` is high.
- R3: While `enable` is 1, successive `adc_rc` falling edges are exactly the effective period apart. While `enable` is 0, no conversion is started.
- R4: Each result is reported by a single-cycle `smp_valid` pulse. `smp_data` carries the 16-bit two's-complement value with bit 15 as the sign, copied into every bit above bit 15.
- R5: The result is read only after the two-flop-synchronised busy flag has risen. Exactly one sample is produced per completed conversion, and none is produced for a conversion that is not completed.
- R6: If busy has not risen within `TIMEOUT_CYC` cycles of the start of `ST_SETUP`, `timeout_err` goes to 1 and stays at 1 until reset. No sample is produced for that conversion, and later conversions proceed normally.
- R7: Starting one cycle after the synchronised status is seen high, `adc_cs_n`, `adc_rc` and `smp_valid` are 0 for as long as the status remains high. A conversion in flight is discarded.
- R8: After the status input falls, `adc_rc` stays low for 3 + `SETTLE_CYC` cycles: two for synchronisation, one for the state register, then the settle interval. The first sample after that has `smp_suspect` = 1 and later samples have 0.
- R9: The effective period is the larger of `period_cfg` and `MIN_PERIOD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows periodic conversions |
| period_cfg | input | PER_W | Requested sample period in clock cycles |
| adc_busy | input | 1 | Converter busy flag (low while converting), asynchronous |
| adc_status | input | 1 | Converter latchup-protection status (high = protected), asynchronous |
| adc_data | input | DATA_W | Converter parallel result, two's complement |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_rc | output | 1 | Read/convert control; a falling edge starts a conversion |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_data | output | OUT_W | Sign-extended sample |
| smp_suspect | output | 1 | Sample is the first one after a protection event |
| timeout_err | output | 1 | Sticky flag for a missing busy return |

## Verification
Each kind of state error shows up at the ports within a few cycles:
- A state machine stuck in the wrong state is seen at the control pins on the next conversion. The `adc_rc` low-pulse width, the chip-select lead cycle, or the spacing between falling edges shifts by at least one cycle, and the bench measures all three exactly.
- A capture that happens early reads the placeholder word the converter stub holds while busy, so the sample scoreboard flags it on that same sample.
- Errors in protection handling show within one conversion. A conversion that is not discarded, an off-by-one settle count, or a suspect flag that is never set or never cleared all appear as a wrong control level, a wrong recovery delay, or a mismatched suspect bit on the first sample after recovery.

// File: rtl/sar_host_pkg.sv
`timescale 1ns/1ps
package sar_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_PULSE,
        ST_WAIT,
        ST_CAPTURE,
        ST_PROTECT,
        ST_SETTLE
    } ctl_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sar_sync2.sv
`timescale 1ns/1ps
module sar_sync2 #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;

endmodule

// File: rtl/sar_rate_timer.sv
`timescale 1ns/1ps
module sar_rate_timer #(
    parameter int PER_W      = 16,
    parameter int MIN_PERIOD = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PER_W-1:0] period_i,
    output logic             tick_o
);

    localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PERIOD);

    logic [PER_W-1:0] eff_period;
    logic [PER_W-1:0] cnt_q;

    // clamp the requested period to the shortest legal cycle
    assign eff_period = (period_i < MIN_P) ? MIN_P : period_i;
    assign tick_o     = run_i && (cnt_q == eff_period - PER_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + PER_W'(1);
        end
    end

endmodule

// File: rtl/sar_host_ctrl.sv
`timescale 1ns/1ps
module sar_host_ctrl
    import sar_host_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int OUT_W       = 24,
    parameter int PER_W       = 16,
    parameter int MIN_PERIOD  = 2000,
    parameter int PULSE_MIN   = 4,
    parameter int TIMEOUT_CYC = 1800,
    parameter int SETTLE_CYC  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PER_W-1:0]  period_cfg,
    input  logic              adc_busy,
    input  logic              adc_status,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_cs_n,
    output logic              adc_rc,
    output logic              smp_valid,
    output logic [OUT_W-1:0]  smp_data,
    output logic              smp_suspect,
    output logic              timeout_err
);

    localparam int CNT_MAX = max3(TIMEOUT_CYC, SETTLE_CYC, PULSE_MIN) + 1;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int EXT_W   = OUT_W - DATA_W;

    ctl_state_e       state_q, state_d;
    logic [CNT_W-1:0] phase_cnt;
    logic             busy_s, prot_s, busy_d;
    logic             busy_rise;
    logic             tick;
    logic             timer_run;
    logic             tmo_hit;
    logic             suspect_pend;

    // busy resets high (idle), status resets low (not protected)
    sar_sync2 #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({adc_status, adc_busy}),
        .q_o   ({prot_s, busy_s})
    );

    assign timer_run = enable && (state_q != ST_PROTECT) && (state_q != ST_SETTLE);

    sar_rate_timer #(.PER_W(PER_W), .MIN_PERIOD(MIN_PERIOD)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (timer_run),
        .period_i (period_cfg),
        .tick_o   (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_d <= 1'b1;
        else        busy_d <= busy_s;
    end

    assign busy_rise = busy_s && !busy_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        tmo_hit = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (tick) state_d = ST_SETUP;
            ST_SETUP:   state_d = ST_PULSE;
            ST_PULSE:   if (phase_cnt == CNT_W'(PULSE_MIN)) state_d = ST_WAIT;
            ST_WAIT: begin
                if (busy_rise) begin
                    state_d = ST_CAPTURE;
                end else if (phase_cnt >= CNT_W'(TIMEOUT_CYC)) begin
                    state_d = ST_IDLE;
                    tmo_hit = 1'b1;
                end
            end
            ST_CAPTURE: state_d = ST_IDLE;
            ST_PROTECT: if (!prot_s) state_d = ST_SETTLE;
            ST_SETTLE:  if (phase_cnt == CNT_W'(SETTLE_CYC - 1)) state_d = ST_IDLE;
        endcase
        if (prot_s) begin
            state_d = ST_PROTECT;
            tmo_hit = 1'b0;
        end
    end

    // state register and shared phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_cnt <= '0;
        end else begin
            state_q <= state_d;
            // the counter keeps running from SETUP through WAIT so it times the whole conversion
            if (state_d != state_q &&
                !(state_q == ST_SETUP && state_d == ST_PULSE) &&
                !(state_q == ST_PULSE && state_d == ST_WAIT)) begin
                phase_cnt <= '0;
            end else if (phase_cnt != CNT_W'(CNT_MAX)) begin
                phase_cnt <= phase_cnt + CNT_W'(1);
            end
        end
    end

    // converter-facing outputs
    always_comb begin
        adc_cs_n = 1'b1;
        adc_rc   = 1'b1;
        unique case (state_q)
            ST_IDLE:    begin adc_cs_n = 1'b1; adc_rc = 1'b1; end
            ST_SETUP:   begin adc_cs_n = 1'b0; adc_rc = 1'b1; end
            ST_PULSE:   begin adc_cs_n = 1'b0; adc_rc = 1'b0; end
            ST_WAIT:    begin adc_cs_n = 1'b0; adc_rc = 1'b1; end
            ST_CAPTURE: begin adc_cs_n = 1'b0; adc_rc = 1'b1; end
            ST_PROTECT: begin adc_cs_n = 1'b0; adc_rc = 1'b0; end
            ST_SETTLE:  begin adc_cs_n = 1'b0; adc_rc = 1'b0; end
        endcase
    end

    // sample stream, suspect marking and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_valid    <= 1'b0;
            smp_data     <= '0;
            smp_suspect  <= 1'b0;
            suspect_pend <= 1'b0;
            timeout_err  <= 1'b0;
        end else begin
            smp_valid <= 1'b0;
            if (state_q == ST_PROTECT) begin
                suspect_pend <= 1'b1;
            end
            if (state_q == ST_CAPTURE && !prot_s) begin
                smp_valid    <= 1'b1;
                smp_data     <= {{EXT_W{adc_data[DATA_W-1]}}, adc_data};
                smp_suspect  <= suspect_pend;
                suspect_pend <= 1'b0;
            end
            if (tmo_hit) begin
                timeout_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_host_ctrl_chk.sv
`timescale 1ns/1ps
module sar_host_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int OUT_W  = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_cs_n,
    input logic             adc_rc,
    input logic             smp_valid,
    input logic [OUT_W-1:0] smp_data,
    input logic             timeout_err,
    input logic             prot_s
);

    // R2
    rc_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rc |-> !adc_cs_n);

    // R4
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R4
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> ((&smp_data[OUT_W-1:DATA_W-1]) || !(|smp_data[OUT_W-1:DATA_W-1])));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> timeout_err);

    // R7
    prot_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_s |=> (!adc_cs_n && !adc_rc && !smp_valid));

endmodule

bind sar_host_ctrl sar_host_ctrl_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .adc_cs_n    (adc_cs_n),
    .adc_rc      (adc_rc),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .timeout_err (timeout_err),
    .prot_s      (prot_s)
);

// File: tb/sar_host_ctrl_tb.sv
`timescale 1ns/1ps
module sar_host_ctrl_tb;

    localparam int DW   = 16;
    localparam int OW   = 24;
    localparam int PW   = 16;
    localparam int MINP = 60;
    localparam int PUL  = 3;
    localparam int TMO  = 40;
    localparam int SET  = 10;
    localparam int CONV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [PW-1:0] period_cfg = 16'd80;
    logic          adc_busy;
    logic          adc_status = 1'b0;
    logic [DW-1:0] adc_data;
    logic          adc_cs_n, adc_rc, smp_valid, smp_suspect, timeout_err;
    logic [OW-1:0] smp_data;

    always #2.5 clk = ~clk;

    sar_host_ctrl #(
        .DATA_W(DW), .OUT_W(OW), .PER_W(PW), .MIN_PERIOD(MINP),
        .PULSE_MIN(PUL), .TIMEOUT_CYC(TMO), .SETTLE_CYC(SET)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period_cfg(period_cfg),
        .adc_busy(adc_busy), .adc_status(adc_status), .adc_data(adc_data),
        .adc_cs_n(adc_cs_n), .adc_rc(adc_rc), .smp_valid(smp_valid),
        .smp_data(smp_data), .smp_suspect(smp_suspect), .timeout_err(timeout_err)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- converter stub ----------------
    logic [DW-1:0] stub_q[$];
    logic          hang = 1'b0;
    logic          rc_q = 1'b1, cs_q = 1'b1, active = 1'b0;
    int            conv_left = 0;

    always @(posedge clk) begin
        rc_q <= adc_rc;
        cs_q <= adc_cs_n;
        if (!rst_n || adc_status) begin
            adc_busy <= 1'b1;
            active   <= 1'b0;
            adc_data <= 16'h5A5A;
        end else if (!active && ((rc_q && !adc_rc && !adc_cs_n) ||
                                 (cs_q && !adc_cs_n && !adc_rc))) begin
            active    <= 1'b1;
            adc_busy  <= 1'b0;
            conv_left <= CONV;
            adc_data  <= 16'hA5C3;
        end else if (active && !hang) begin
            if (conv_left == 0) begin
                active   <= 1'b0;
                adc_busy <= 1'b1;
                if (stub_q.size() != 0) adc_data <= stub_q.pop_front();
                else                    adc_data <= 16'h0000;
            end else begin
                conv_left <= conv_left - 1;
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [OW:0] exp_q[$];

    task automatic push_sample(input logic [DW-1:0] v, input logic susp);
        stub_q.push_back(v);
        exp_q.push_back({susp, {(OW-DW){v[DW-1]}}, v});
    endtask

    always @(negedge clk) begin
        if (rst_n && smp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "sample with nothing expected", smp_data, 0);
            end else begin
                logic [OW:0] e;
                e = exp_q.pop_front();
                chk(smp_data == e[OW-1:0], "R4", "sign-extended data", smp_data, e[OW-1:0]);
                chk(smp_suspect == e[OW], "R8", "suspect flag", smp_suspect, e[OW]);
            end
        end
    end

    // ---------------- control pin monitor ----------------
    logic   rc_prev = 1'b1, cs_prev = 1'b1;
    logic   in_prot = 1'b0, per_chk = 1'b0;
    int     exp_per = 80;
    int     low_run = 0;
    int     n_falls = 0;
    longint last_fall = -1;

    always @(negedge clk) begin
        if (!per_chk) last_fall = -1;
        if (rst_n && !in_prot) begin
            if (rc_prev && !adc_rc) begin
                chk(cs_prev == 1'b0, "R2", "cs_n low before rc falls", cs_prev, 0);
                if (per_chk && last_fall >= 0)
                    chk(cyc - last_fall == exp_per, "R3", "start spacing", cyc - last_fall, exp_per);
                last_fall = cyc;
                low_run = 1;
                n_falls++;
            end else if (!adc_rc) begin
                low_run++;
            end
            if (!rc_prev && adc_rc && low_run > 0) begin
                chk(low_run == PUL, "R2", "rc low pulse width", low_run, PUL);
                low_run = 0;
            end
        end else begin
            low_run = 0;
        end
        rc_prev = adc_rc;
        cs_prev = adc_cs_n;
    end

    task automatic wait_empty(input string req, input int limit);
        for (int i = 0; i < limit && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, req, "all expected samples seen", exp_q.size(), 0);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int f0, k;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(adc_cs_n == 1'b1, "R1", "cs_n at reset", adc_cs_n, 1);
        chk(adc_rc == 1'b1, "R1", "rc at reset", adc_rc, 1);
        chk(smp_valid == 1'b0, "R1", "valid at reset", smp_valid, 0);
        chk(timeout_err == 1'b0, "R1", "timeout_err at reset", timeout_err, 0);
        chk(smp_suspect == 1'b0, "R1", "suspect at reset", smp_suspect, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 / R4 / R5: boundary codes at the programmed period
        push_sample(16'h7FFF, 1'b0);
        push_sample(16'h8000, 1'b0);
        push_sample(16'hFFFF, 1'b0);
        push_sample(16'h0001, 1'b0);
        push_sample(16'h1234, 1'b0);
        exp_per = 80;
        per_chk = 1'b1;
        enable  = 1'b1;
        wait_empty("R5", 1500);
        enable  = 1'b0;
        per_chk = 1'b0;
        repeat (10) @(negedge clk);

        // R9: period below the minimum is clamped
        period_cfg = 16'd5;
        push_sample(16'h4000, 1'b0);
        push_sample(16'hC000, 1'b0);
        push_sample(16'h0000, 1'b0);
        exp_per = MINP;
        per_chk = 1'b1;
        enable  = 1'b1;
        wait_empty("R9", 1000);
        enable  = 1'b0;
        per_chk = 1'b0;

        // R3: disabled, no conversion starts
        f0 = n_falls;
        repeat (300) @(negedge clk);
        chk(n_falls == f0, "R3", "no start while disabled", n_falls - f0, 0);

        // R7 / R8: protection during a conversion
        period_cfg = 16'd80;
        push_sample(16'h2222, 1'b1);
        push_sample(16'hDDDD, 1'b0);
        enable = 1'b1;
        while (adc_rc) @(negedge clk);
        repeat (PUL + 2) @(negedge clk);
        in_prot    = 1'b1;
        adc_status = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            chk(!adc_cs_n && !adc_rc, "R7", "lines low while protected", {adc_cs_n, adc_rc}, 0);
            @(negedge clk);
        end
        chk(exp_q.size() == 2, "R7", "in-flight conversion discarded", exp_q.size(), 2);
        adc_status = 1'b0;
        k = 0;
        while (!adc_rc && k < 200) begin
            @(negedge clk);
            k++;
        end
        chk(k == SET + 3, "R8", "recovery delay", k, SET + 3);
        in_prot = 1'b0;
        wait_empty("R8", 1000);
        enable = 1'b0;
        repeat (10) @(negedge clk);

        // R6: busy never returns
        period_cfg = 16'd200;
        hang   = 1'b1;
        enable = 1'b1;
        k = 0;
        while (!timeout_err && k < 600) begin
            @(negedge clk);
            k++;
        end
        chk(timeout_err == 1'b1, "R6", "timeout flagged", timeout_err, 1);
        hang = 1'b0;
        repeat (30) @(negedge clk);
        chk(timeout_err == 1'b1, "R6", "timeout sticky", timeout_err, 1);
        push_sample(16'hC001, 1'b0);
        wait_empty("R6", 800);
        chk(timeout_err == 1'b1, "R6", "timeout still set", timeout_err, 1);
        enable = 1'b0;
        repeat (10) @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule